// File: doc/BRIEF.md
# Split-Mapped Internal Data Memory

This block is the on-chip data store of a small 8-bit controller core, together with a front end that knows which addressing mode made each access. It holds 256 bytes. Every request carries an 8-bit address and a flag that says whether the address came from the instruction itself (direct) or from a pointer register (indirect). The lower half of the address space always lands in the array. The upper half is shared: a direct access there goes out on a special-function-register port, and an indirect access reaches the upper 128 bytes of the array.

The core issues at most one byte read or one byte write per clock. Read data is registered and appears one clock after the request. The SFR port is a plain pass-through bus. The registers behind it belong to other blocks, and their read data is sampled in the request cycle. The array is never cleared; reset only touches the read register.

Top module: `splitmap_ram`

## Requirements
- R1: A direct access (`indirect`=0) with address 00h–7Fh writes or reads the array location of that address, and `sfrRd`/`sfrWr` stay 0.
- R2: A direct access with address 80h–FFh (address bit 7 set) asserts `sfrWr` (for a write) or `sfrRd` (for a read) in the same cycle, with `sfrAddr` equal to `addr` and `sfrWdata` equal to `wdata`, and leaves the array unchanged.
- R3: An indirect access (`indirect`=1) at any address 00h–FFh targets the array location of that address and never asserts `sfrRd` or `sfrWr`.
- R4: An array byte and the SFR at the same upper address are independent: a direct write to address A does not change what an indirect read of A returns, and an indirect write to A does not change what a direct read of A returns.
- R5: After a read request at clock edge N, `rdata` holds the result from edge N until the next load. The result is the array byte, or the `sfrRdata` value present in the request cycle, chosen by the decode of that cycle.
- R6: In a cycle without a read request, `rdata` keeps its value.
- R7: While `rst_n` is low, `rdata` is 00h and both SFR strobes are 0. Reset does not alter the array contents.
- R8: When `rd` and `wr` are both 1, only the write happens: `sfrRd` stays 0, `rdata` keeps its value, and the write proceeds as in R1–R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the request |
| indirect | input | 1 | 1 = pointer (indirect) access, 0 = direct access |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request (wins over `rd`) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sfrAddr | output | 8 | SFR bus address |
| sfrRd | output | 1 | SFR read strobe |
| sfrWr | output | 1 | SFR write strobe |
| sfrWdata | output | 8 | SFR write data |
| sfrRdata | input | 8 | SFR read data, sampled in the request cycle |

## Verification
The assertions assume that the SFR side returns `sfrRdata` combinationally in the cycle in which `sfrRd` is high. They also assume that `addr`, `indirect`, `rd`, `wr` and `wdata` are steady around the active edge. The bench changes these inputs only on the falling clock edge. Its SFR model answers from its own byte store, indexed by `sfrAddr` through a continuous assignment. The bench writes every array byte before reading it, so it never compares against uninitialised memory contents.

// File: rtl/splitmap_pkg.sv
package splitmap_pkg;

  // Per-cycle strobes handed from the decoder to the storage datapath.
  typedef struct packed {
    logic ramWr;   // write the array at the request address
    logic ramRd;   // load rdata from the array
    logic sfrRd;   // load rdata from the SFR bus
  } memStrobe_t;

endpackage

// File: rtl/splitmap_ctrl.sv
module splitmap_ctrl
  import splitmap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              indirect,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output memStrobe_t        stb,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic              sfrRd,
  output logic              sfrWr,
  output logic [DATA_W-1:0] sfrWdata
);

  // The top address bit splits the map into a shared upper half.
  localparam int SplitBit = ADDR_W - 1;

  logic upperHalf;
  logic toSfr;
  logic doRead;

  always_comb begin
    upperHalf = addr[SplitBit];
    // Only a direct access to the upper half leaves the block.
    toSfr     = upperHalf && !indirect;
    // A simultaneous write suppresses the read entirely.
    doRead    = rd && !wr;

    stb.ramWr = wr && !toSfr;
    stb.ramRd = doRead && !toSfr;
    stb.sfrRd = doRead && toSfr;

    sfrRd     = stb.sfrRd;
    sfrWr     = wr && toSfr;
    sfrAddr   = addr;
    sfrWdata  = wdata;
  end

endmodule

// File: rtl/splitmap_dpath.sv
module splitmap_dpath
  import splitmap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  memStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int Depth = 1 << ADDR_W;

  // Storage array: deliberately left without reset.
  logic [DATA_W-1:0] memArray [Depth];
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (stb.ramWr) begin
      memArray[addr] <= wdata;
    end
  end

  // One output register, loaded from whichever source was decoded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdataQ <= '0;
    end else if (stb.ramRd) begin
      rdataQ <= memArray[addr];
    end else if (stb.sfrRd) begin
      rdataQ <= sfrRdata;
    end
  end

  assign rdata = rdataQ;

endmodule

// File: rtl/splitmap_ram.sv
module splitmap_ram
  import splitmap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              indirect,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic              sfrRd,
  output logic              sfrWr,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata
);

  memStrobe_t stb;
  logic       sfrRdRaw;
  logic       sfrWrRaw;

  splitmap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .addr     (addr),
    .indirect (indirect),
    .rd       (rd),
    .wr       (wr),
    .wdata    (wdata),
    .stb      (stb),
    .sfrAddr  (sfrAddr),
    .sfrRd    (sfrRdRaw),
    .sfrWr    (sfrWrRaw),
    .sfrWdata (sfrWdata)
  );

  splitmap_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .addr     (addr),
    .wdata    (wdata),
    .sfrRdata (sfrRdata),
    .rdata    (rdata)
  );

  // No bus strobe may escape while the block is held in reset.
  assign sfrRd = sfrRdRaw && rst_n;
  assign sfrWr = sfrWrRaw && rst_n;

endmodule

// File: rtl/splitmap_ram_chk.sv
module splitmap_ram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              indirect,
  input logic              rd,
  input logic              wr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] sfrAddr,
  input logic              sfrRd,
  input logic              sfrWr,
  input logic [DATA_W-1:0] sfrWdata,
  input logic [DATA_W-1:0] sfrRdata
);

  // R3: pointer accesses never reach the SFR bus.
  a_r3_indirect_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    indirect |-> (!sfrRd && !sfrWr));

  // R1: direct lower-half accesses stay local as well.
  a_r1_low_direct_local: assert property (@(posedge clk) disable iff (!rst_n)
    (!indirect && !addr[ADDR_W-1]) |-> (!sfrRd && !sfrWr));

  // R2: a bus strobe only for a direct upper-half request, with address and data passed through.
  a_r2_sfr_bus_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (sfrRd || sfrWr) |-> (!indirect && addr[ADDR_W-1] && sfrAddr == addr
                          && (rd || wr) && (!sfrWr || sfrWdata == wdata)));

  // R2: a direct upper-half write always appears on the bus.
  a_r2_sfr_write_issued: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !indirect && addr[ADDR_W-1]) |-> sfrWr);

  // R8: write wins, so no SFR read strobe during a combined request.
  a_r8_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> !sfrRd);

  // R5: an SFR read returns the bus data of the request cycle.
  a_r5_sfr_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    sfrRd |=> (rdata == $past(sfrRdata)));

  // R6: without a read, rdata holds.
  a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd || wr) |=> $stable(rdata));

  // R7: strobes are quiet while reset is low.
  always_comb begin
    if (!rst_n) begin
      a_r7_reset_quiet: assert (!sfrRd && !sfrWr);
    end
  end

endmodule

bind splitmap_ram splitmap_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .indirect (indirect),
  .rd       (rd),
  .wr       (wr),
  .wdata    (wdata),
  .rdata    (rdata),
  .sfrAddr  (sfrAddr),
  .sfrRd    (sfrRd),
  .sfrWr    (sfrWr),
  .sfrWdata (sfrWdata),
  .sfrRdata (sfrRdata)
);

// File: tb/splitmap_ram_test.sv
`timescale 1ns/1ps
module splitmap_ram_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       indirect = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] sfrAddr;
  logic       sfrRd;
  logic       sfrWr;
  logic [7:0] sfrWdata;
  logic [7:0] sfrRdata;

  // Behavioural models: array contents, the SFR bank and the expected read register.
  logic [7:0] ramModel [256];
  logic [7:0] sfrBank  [256];
  logic [7:0] expRdata;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign sfrRdata = sfrBank[sfrAddr];

  splitmap_ram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .indirect(indirect), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .sfrAddr(sfrAddr), .sfrRd(sfrRd), .sfrWr(sfrWr),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One request cycle: drive on the falling edge, check the bus, then check rdata after the edge.
  task automatic cycle(input string req, input logic [7:0] a, input logic ind,
                       input logic r, input logic w, input logic [7:0] d);
    logic toSfr, expSfrRd, expSfrWr;
    @(negedge clk);
    addr = a; indirect = ind; rd = r; wr = w; wdata = d;
    toSfr    = a[7] && !ind;
    expSfrRd = r && !w && toSfr;
    expSfrWr = w && toSfr;
    #1;
    check(req, "sfrRd", sfrRd, expSfrRd);
    check(req, "sfrWr", sfrWr, expSfrWr);
    if (expSfrRd || expSfrWr) check(req, "sfrAddr", sfrAddr, a);
    if (expSfrWr) check(req, "sfrWdata", sfrWdata, d);
    if (!w && r) expRdata = toSfr ? sfrBank[a] : ramModel[a];
    @(posedge clk);
    if (w) begin
      if (toSfr) sfrBank[a] = d;
      else       ramModel[a] = d;
    end
    #1;
    check(req, "rdata", rdata, expRdata);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) sfrBank[i] = 8'(i ^ 8'hA5);
    expRdata = 8'h00;
    #5;
    check("R7", "rdata in reset", rdata, 0);
    check("R7", "sfrRd in reset", sfrRd, 0);
    check("R7", "sfrWr in reset", sfrWr, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R1: lower-half direct accesses
    cycle("R1", 8'h00, 0, 0, 1, 8'h11);
    cycle("R1", 8'h7F, 0, 0, 1, 8'h22);
    cycle("R1", 8'h40, 0, 0, 1, 8'h33);
    cycle("R1", 8'h00, 0, 1, 0, 8'h00);
    cycle("R5", 8'h7F, 0, 1, 0, 8'h00);
    cycle("R5", 8'h40, 0, 1, 0, 8'h00);

    // R3: indirect accesses across both halves
    cycle("R3", 8'h80, 1, 0, 1, 8'h44);
    cycle("R3", 8'h90, 1, 0, 1, 8'h55);
    cycle("R3", 8'hFF, 1, 0, 1, 8'h66);
    cycle("R3", 8'h90, 1, 1, 0, 8'h00);
    cycle("R3", 8'hFF, 1, 1, 0, 8'h00);
    cycle("R3", 8'h40, 1, 1, 0, 8'h00);

    // R2/R4: same address through both paths
    cycle("R2", 8'h90, 0, 0, 1, 8'hC3);
    cycle("R4", 8'h90, 1, 1, 0, 8'h00);
    cycle("R4", 8'h90, 0, 1, 0, 8'h00);
    cycle("R4", 8'h90, 1, 0, 1, 8'h5A);
    cycle("R4", 8'h90, 0, 1, 0, 8'h00);
    cycle("R2", 8'hFF, 0, 1, 0, 8'h00);

    // R6: idle cycles hold rdata
    cycle("R6", 8'h00, 0, 0, 0, 8'h00);
    cycle("R6", 8'h80, 1, 0, 0, 8'h00);

    // R8: rd and wr together
    cycle("R8", 8'h20, 0, 1, 1, 8'h77);
    cycle("R8", 8'h20, 0, 1, 0, 8'h00);
    cycle("R8", 8'hA0, 0, 1, 1, 8'h88);
    cycle("R8", 8'hA0, 0, 1, 0, 8'h00);
    cycle("R8", 8'hB0, 1, 1, 1, 8'h99);
    cycle("R8", 8'hB0, 1, 1, 0, 8'h00);

    // R7: reset mid-run keeps the array
    @(negedge clk);
    rd = 0; wr = 0;
    rst_n = 1'b0;
    #1;
    expRdata = 8'h00;
    check("R7", "rdata after reset", rdata, 0);
    check("R7", "sfrRd in reset", sfrRd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle("R7", 8'h20, 0, 1, 0, 8'h00);
    cycle("R7", 8'hFF, 1, 1, 0, 8'h00);

    // R4: full sweep, array via pointer and SFR bank via direct
    for (int i = 0; i < 256; i++) cycle("R3", 8'(i), 1, 0, 1, 8'((i * 7) ^ 8'h3C));
    for (int i = 128; i < 256; i++) cycle("R2", 8'(i), 0, 0, 1, 8'(i + 3));
    for (int i = 0; i < 256; i++) cycle("R4", 8'(i), 1, 1, 0, 8'h00);
    for (int i = 0; i < 256; i++) cycle("R4", 8'(i), 0, 1, 0, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule